// File: doc/BRIEF.md
# Two-Cycle Ternary Bit-Manipulation ALU

This block is a 32-bit execution unit that performs six bit-manipulation operations. Four of them take three source operands: conditional mix, conditional move, funnel shift left and funnel shift right. The other two are rotate left and rotate right. Each operation runs on a two-input datapath over exactly two clock cycles. In the first cycle the unit works on the first and second sources and keeps a partial result in a stage register. In the second cycle it combines that partial result with work done on the third and second sources.

The pipeline asserts `start` with an operation code and the three sources. The unit accepts the request in that cycle and raises `busy` at once, so the pipeline stalls. The pipeline holds all three sources steady through the following cycle. In that second cycle `busy` is low, `resultValid` pulses and `result` carries the answer. A single shifter, one bit wider than the data, serves both rotations and funnel shifts. The extra bit lets a shift by the full word width clear the operand without needing a special case.

Top module: `ternary_bitalu`

## Requirements
- R1: A request is accepted when `start` is high, the unit is not in a second cycle and the code is supported. `resultValid` is then high for exactly the one cycle that follows. `result` is zero whenever `resultValid` is low.
- R2: `busy` is high during the cycle in which a request is accepted. It is low in the second cycle.
- R3: Code 5 (rotate right) with s = srcB[4:0] returns srcA rotated right by s.
- R4: Code 4 (rotate left) with s = srcB[4:0] returns srcA rotated left by s.
- R5: Code 3 (funnel right) with s = srcB[4:0]: if srcB[5] is 0, A = srcA and B = srcC; if it is 1, the two are swapped. The unit returns (A >> s) | (B << (32 - s)), and A when s = 0. So an amount of 0 gives srcA and an amount of 32 gives srcC.
- R6: Code 2 (funnel left) uses the same A, B and s as R5. It returns (A << s) | (B >> (32 - s)), and A when s = 0.
- R7: Code 1 (conditional move) returns srcA when srcB is nonzero and srcC when srcB is zero.
- R8: Code 0 (conditional mix) returns (srcA & srcB) | (srcC & ~srcB).
- R9: A `start` raised during the second cycle is ignored. It does not raise `busy`, it does not change that cycle's result and it produces no result in the next cycle.
- R10: Codes 6 and 7 are ignored. They raise neither `busy` nor `resultValid`.
- R11: A synchronous active-low reset clears the stage register and the cycle state, including a cycle that is in progress. After reset `busy`, `resultValid` and `result` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe |
| opSel | input | 3 | Operation code (0 mix, 1 move, 2 funnel left, 3 funnel right, 4 rotate left, 5 rotate right) |
| srcA | input | 32 | First source, held for both cycles |
| srcB | input | 32 | Second source (condition, mask or shift amount), held for both cycles |
| srcC | input | 32 | Third source, held for both cycles |
| result | output | 32 | Result, valid in the second cycle |
| resultValid | output | 1 | One-cycle pulse marking the result |
| busy | output | 1 | Stall request in the accepting cycle |

## Verification
The bench sweeps every shift amount from 0 to 63 for each operation over four operand patterns. This covers the amounts 0 and 32 and the swap at bit 5. If either step of the funnel logic mishandled those amounts, it would OR in a stray copy of an operand or return the wrong source. A move whose condition is exactly zero catches a unit that tests only some bits of srcB. A new request in the second cycle, or a request with an unsupported code, must leave the result and both flags untouched. A design that restarted on such a request would emit an extra valid pulse. A reset asserted in mid-operation must drop the pending result.

// File: rtl/ternary_bitalu_pkg.sv
package ternary_bitalu_pkg;
  localparam int unsigned OP_W = 3;

  localparam logic [OP_W-1:0] OP_CMIX = 3'd0;
  localparam logic [OP_W-1:0] OP_CMOV = 3'd1;
  localparam logic [OP_W-1:0] OP_FSL  = 3'd2;
  localparam logic [OP_W-1:0] OP_FSR  = 3'd3;
  localparam logic [OP_W-1:0] OP_ROL  = 3'd4;
  localparam logic [OP_W-1:0] OP_ROR  = 3'd5;
  localparam logic [OP_W-1:0] OP_LAST = OP_ROR;

  // strobes from control to datapath
  typedef struct packed {
    logic            capture;  // first cycle: load stage register
    logic            finish;   // second cycle: produce result
    logic [OP_W-1:0] op;       // operation steering the datapath
  } ctrl_t;
endpackage

// File: rtl/ternary_bitalu_shift.sv
// Right shifter one bit wider than the data; left shifts by reversal.
module ternary_bitalu_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,      // 0..W
  input  logic          dirLeft,
  input  logic          fillBit,
  output logic [W-1:0]  dout
);
  logic [W-1:0] dinOrd;
  logic [W:0]   extVal;
  logic [W:0]   shifted;
  logic [W-1:0] resOrd;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      dinOrd[i] = dirLeft ? din[W-1-i] : din[i];
    end
    extVal  = {fillBit, dinOrd};
    shifted = extVal >> amt;
    for (int i = 0; i < W; i++) begin
      resOrd[i] = dirLeft ? shifted[W-1-i] : shifted[i];
    end
    dout = resOrd;
  end
endmodule

// File: rtl/ternary_bitalu_ctrl.sv
module ternary_bitalu_ctrl
  import ternary_bitalu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] opIn,
  output ctrl_t           ctrl,
  output logic            busy
);
  logic            inSecond;
  logic [OP_W-1:0] opHeld;
  logic            opSupported;
  logic            launch;

  assign opSupported = (opIn <= OP_LAST);
  assign launch      = start && !inSecond && opSupported;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inSecond <= 1'b0;
      opHeld   <= '0;
    end else begin
      inSecond <= launch;
      if (launch) opHeld <= opIn;
    end
  end

  always_comb begin
    ctrl.capture = launch;
    ctrl.finish  = inSecond;
    ctrl.op      = inSecond ? opHeld : opIn;
  end

  assign busy = launch;
endmodule

// File: rtl/ternary_bitalu_dp.sv
module ternary_bitalu_dp
  import ternary_bitalu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrl_t        ctrl,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  input  logic [W-1:0] srcC,
  output logic [W-1:0] result
);
  localparam int unsigned SW = $clog2(W);
  localparam int unsigned AW = SW + 1;

  logic [W-1:0]  stageQ;
  logic [W-1:0]  opA;
  logic [W-1:0]  opB;
  logic          isTernary;
  logic          isRotate;
  logic          isFunnel;
  logic          opLeft;
  logic          swapRoles;
  logic [AW-1:0] amtMain;
  logic [AW-1:0] amtComp;
  logic [AW-1:0] amtRotComp;
  logic          mainSide;
  logic [AW-1:0] shAmt;
  logic          shLeft;
  logic [W-1:0]  shOut;
  logic [W-1:0]  bwOut;
  logic [W-1:0]  firstVal;
  logic [W-1:0]  secondVal;

  assign isRotate  = (ctrl.op == OP_ROL) || (ctrl.op == OP_ROR);
  assign isFunnel  = (ctrl.op == OP_FSL) || (ctrl.op == OP_FSR);
  assign isTernary = !isRotate;
  assign opLeft    = (ctrl.op == OP_FSL) || (ctrl.op == OP_ROL);

  // operand steering: second cycle of a ternary op sees srcC, srcB
  assign opA = (ctrl.finish && isTernary) ? srcC : srcA;
  assign opB = srcB;

  assign swapRoles  = isFunnel && opB[SW];
  assign amtMain    = {1'b0, opB[SW-1:0]};
  assign amtComp    = AW'(W) - amtMain;
  assign amtRotComp = {1'b0, amtComp[SW-1:0]};

  // main side: shift in the op direction by the amount
  assign mainSide = ctrl.finish ? swapRoles : !swapRoles;

  always_comb begin
    if (mainSide) begin
      shLeft = opLeft;
      shAmt  = amtMain;
    end else begin
      shLeft = !opLeft;
      shAmt  = isRotate ? amtRotComp : amtComp;
    end
  end

  ternary_bitalu_shift #(.W(W), .AW(AW)) u_shift (
    .din     (opA),
    .amt     (shAmt),
    .dirLeft (shLeft),
    .fillBit (1'b0),
    .dout    (shOut)
  );

  // shared bitwise path: a & b first, a & ~b second
  assign bwOut = opA & (ctrl.finish ? ~opB : opB);

  always_comb begin
    case (ctrl.op)
      OP_CMIX: firstVal = bwOut;
      OP_CMOV: firstVal = opA;
      default: firstVal = shOut;
    endcase
  end

  always_comb begin
    case (ctrl.op)
      OP_CMIX: secondVal = stageQ | bwOut;
      OP_CMOV: secondVal = (opB != '0) ? stageQ : opA;
      default: secondVal = stageQ | shOut;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           stageQ <= '0;
    else if (ctrl.capture) stageQ <= firstVal;
  end

  assign result = ctrl.finish ? secondVal : '0;
endmodule

// File: rtl/ternary_bitalu.sv
module ternary_bitalu
  import ternary_bitalu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] opSel,
  input  logic [W-1:0]    srcA,
  input  logic [W-1:0]    srcB,
  input  logic [W-1:0]    srcC,
  output logic [W-1:0]    result,
  output logic            resultValid,
  output logic            busy
);
  ctrl_t ctrl;

  ternary_bitalu_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .opIn  (opSel),
    .ctrl  (ctrl),
    .busy  (busy)
  );

  ternary_bitalu_dp #(.W(W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .srcC   (srcC),
    .result (result)
  );

  assign resultValid = ctrl.finish;
endmodule

// File: rtl/ternary_bitalu_chk.sv
module ternary_bitalu_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [2:0]   opSel,
  input logic [W-1:0] srcA,
  input logic [W-1:0] srcB,
  input logic [W-1:0] srcC,
  input logic [W-1:0] result,
  input logic         resultValid,
  input logic         busy
);
  a_r1_valid_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> resultValid);

  a_r1_valid_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  a_r1_result_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !resultValid |-> (result == '0));

  a_r2_busy_low_second: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> !busy);

  a_r10_bad_code_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel > 3'd5) |-> !busy);

  a_r7_cmov_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && $past(opSel) == 3'd1 && srcB != '0) |-> (result == $past(srcA)));

  a_r11_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!resultValid && result == '0));
endmodule

bind ternary_bitalu ternary_bitalu_chk #(.W(W)) chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .opSel       (opSel),
  .srcA        (srcA),
  .srcB        (srcB),
  .srcC        (srcC),
  .result      (result),
  .resultValid (resultValid),
  .busy        (busy)
);

// File: tb/ternary_bitalu_test.sv
module ternary_bitalu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [31:0] srcC = '0;
  logic [31:0] result;
  logic        resultValid;
  logic        busy;

  int nChecks = 0;
  int nFails  = 0;

  ternary_bitalu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .srcC(srcC),
    .result(result), .resultValid(resultValid), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] c);
    logic [63:0] t;
    logic [31:0] pa, pb;
    logic [4:0]  s;
    s  = b[4:0];
    pa = b[5] ? c : a;
    pb = b[5] ? a : c;
    case (op)
      3'd0: return (a & b) | (c & ~b);
      3'd1: return (b != 0) ? a : c;
      3'd2: begin t = {pa, pb} << s; return t[63:32]; end
      3'd3: begin t = {pb, pa} >> s; return t[31:0]; end
      3'd4: begin t = {a, a} << s; return t[63:32]; end
      default: begin t = {a, a} >> s; return t[31:0]; end
    endcase
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R8 cmix";
      3'd1: return "R7 cmov";
      3'd2: return "R6 fsl";
      3'd3: return "R5 fsr";
      3'd4: return "R4 rol";
      default: return "R3 ror";
    endcase
  endfunction

  // one full operation; leaves the bench at the negedge of the second cycle
  task automatic runOp(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    start = 1'b1; opSel = op; srcA = a; srcB = b; srcC = c;
    #1;
    check("R2 busy in first cycle", {31'd0, busy}, 32'd1);
    @(negedge clk);
    start = 1'b0;
    #1;
    check("R1 valid in second cycle", {31'd0, resultValid}, 32'd1);
    check("R2 busy low in second cycle", {31'd0, busy}, 32'd0);
    check(opTag(op), result, model(op, a, b, c));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] aPat [4];
    logic [31:0] bHi  [4];
    logic [31:0] cPat [4];
    aPat = '{32'h8000_0001, 32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_0000};
    bHi  = '{32'h0000_0000, 32'hF0F0_F0C0, 32'h0F0F_0F00, 32'hAAAA_5540};
    cPat = '{32'h0000_FFFF, 32'h0BAD_F00D, 32'h8765_4321, 32'h7FFF_FFFE};

    repeat (3) @(negedge clk);
    #1;
    check("R11 result after reset", result, 32'd0);
    check("R11 valid after reset", {31'd0, resultValid}, 32'd0);
    check("R11 busy after reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;

    // sweep: every op, every 6-bit amount, four patterns
    for (int op = 0; op < 6; op++) begin
      for (int amt = 0; amt < 64; amt++) begin
        for (int p = 0; p < 4; p++) begin
          runOp(3'(op), aPat[p], bHi[p] | 32'(amt), cPat[p]);
        end
      end
    end

    // R9: start held through the second cycle is ignored
    @(negedge clk);
    start = 1'b1; opSel = 3'd3; srcA = 32'hCAFE_0001; srcB = 32'd7; srcC = 32'h5555_AAAA;
    @(negedge clk);
    opSel = 3'd5;
    #1;
    check("R9 busy low on start in second cycle", {31'd0, busy}, 32'd0);
    check("R9 result unchanged by second start", result, model(3'd3, 32'hCAFE_0001, 32'd7, 32'h5555_AAAA));
    @(negedge clk);
    start = 1'b0;
    #1;
    check("R9 no result after ignored start", {31'd0, resultValid}, 32'd0);

    // R10: unsupported codes
    for (int code = 6; code < 8; code++) begin
      @(negedge clk);
      start = 1'b1; opSel = 3'(code);
      #1;
      check("R10 no busy on bad code", {31'd0, busy}, 32'd0);
      @(negedge clk);
      start = 1'b0;
      #1;
      check("R10 no valid on bad code", {31'd0, resultValid}, 32'd0);
    end

    // R11: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; opSel = 3'd0; srcA = '1; srcB = 32'hFF; srcC = '1;
    @(negedge clk);
    start = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    #1;
    check("R11 valid cleared mid-op", {31'd0, resultValid}, 32'd0);
    check("R11 result cleared mid-op", result, 32'd0);
    rst_n = 1'b1;
    runOp(3'd1, 32'h0000_0042, 32'd0, 32'h0000_0099);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule